// File: doc/BRIEF.md
# Tag-Fault Status Register Access Decoder

This block decides what happens when software names the tag-fault status system register, or one of its two sibling encodings, in a register move instruction. It is purely combinational. Its inputs are the current exception level, the five encoding fields, the transfer direction and the live privilege controls: which higher levels exist, whether EL2 is enabled, host mode, the three nested-virtualization bits, the two tag-access enables and the two secure-debug undefined flags. In the same cycle it returns one action: undefined instruction, trap to EL2, trap to EL3, use the EL1 copy, use the EL2 copy, or redirect to a memory slot.

A trap also carries the exception class that goes into the syndrome. A redirect also carries the byte offset of the slot. The direction input has no effect on the decision. It only qualifies a write enable for the actions that store data. An encoding that is none of the three forms raises a separate no-match flag and leaves all action outputs low. This lets the surrounding decode tree send it to some other register.

Top module: `tfs_access_decoder`

## Requirements
- R1: The block recognises three forms: primary (op0=3, op1=0, CRn=5, CRm=6, op2=0), alias (op1=5, other fields as primary) and EL2-register (op1=4, other fields as primary). Any other encoding drives no_match=1, and act=0, wr_en=0, exc_class=0 and mem_offset=0.
- R2: For a recognised form at cur_el=0, the result is undefined.
- R3: Primary form at EL1 applies these checks in priority order. (a) EL3 present with prio flag set and EL3 tag enable clear gives undefined. (b) nv=3'b011 traps to EL2. (c) EL2 present and enabled with EL2 tag enable clear traps to EL2. (d) EL3 present with EL3 tag enable clear gives undefined when sdd_undef=1, and otherwise traps to EL3. (e) nv=3'b111 redirects to memory. (f) Otherwise the EL1 copy is used. Here nv is written {nv[2],nv[1],nv[0]}.
- R4: Primary form at EL2 applies checks (a) and (d) and then selects the EL2 copy if host=1, or the EL1 copy if host=0. At EL3 (cur_el=3) it always selects the EL1 copy.
- R5: Alias form at EL1 redirects to memory when nv=3'b101. Otherwise it traps to EL2 when nv[0]=1. Otherwise it is undefined.
- R6: Alias form at EL2 or EL3 is undefined when host=0. With host=1, EL2 applies checks (a) and (d) before selecting the EL1 copy, and EL3 selects the EL1 copy directly.
- R7: EL2-register form at EL1 with nv[2]=1 and nv[0]=1 applies checks (a), (c) and (d) and then selects the EL1 copy. Otherwise it traps to EL2 when nv[0]=1, and otherwise it is undefined.
- R8: EL2-register form at EL2 applies checks (a) and (d) and then selects the EL2 copy. At EL3 it always selects the EL2 copy.
- R9: act is one-hot with bit 0 undefined, bit 1 trap EL2, bit 2 trap EL3, bit 3 EL1 copy, bit 4 EL2 copy and bit 5 memory redirect. Exactly one bit is set whenever no_match=0.
- R10: exc_class is 0x18 for either trap and 0 otherwise. mem_offset is 0x190 for a redirect and 0 otherwise.
- R11: The direction input never changes act. wr_en equals is_write ANDed with (act bit 3, 4 or 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_el | input | 2 | Current exception level, 0 to 3 |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| is_write | input | 1 | 1 for a register write, 0 for a read |
| el2_present | input | 1 | EL2 is implemented |
| el3_present | input | 1 | EL3 is implemented |
| el2_enabled | input | 1 | EL2 enabled in the current security state |
| host_mode | input | 1 | EL2 runs as host |
| nv | input | 3 | Nested-virtualization control bits |
| el2_tag_en | input | 1 | EL2 tag-access enable |
| el3_tag_en | input | 1 | EL3 tag-access enable |
| sdd_prio | input | 1 | Secure-debug undefined takes priority |
| sdd_undef | input | 1 | Secure-debug disabled access is undefined |
| act | output | 6 | One-hot action vector |
| no_match | output | 1 | Encoding is none of the three forms |
| exc_class | output | 6 | Syndrome exception class for traps |
| mem_offset | output | 12 | Slot offset for memory redirect |
| wr_en | output | 1 | Write strobe for copy or memory actions |

## Verification
A wrong form match shows up at once as a wrong no_match or as a result taken from the wrong column of the rules. A mis-ordered check only shows up for control patterns in which two checks fire together, for example nv=011 with EL3 tag access disabled. The bench therefore sweeps every combination of levels, encodings and controls, including several near-miss encodings. Because nothing is registered, any defect appears on the ports in the same cycle as the stimulus that triggers it.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  localparam int ACT_W   = 6;
  localparam int A_UNDEF = 0;
  localparam int A_TRAP2 = 1;
  localparam int A_TRAP3 = 2;
  localparam int A_EL1   = 3;
  localparam int A_EL2   = 4;
  localparam int A_MEM   = 5;

  typedef enum logic [1:0] {F_NONE, F_PRI, F_ALIAS, F_EL2R} form_e;

  localparam logic [1:0] OP0_SYS   = 2'd3;
  localparam logic [2:0] OP1_PRI   = 3'd0;
  localparam logic [2:0] OP1_ALIAS = 3'd5;
  localparam logic [2:0] OP1_EL2R  = 3'd4;
  localparam logic [3:0] CRN_TFS   = 4'd5;
  localparam logic [3:0] CRM_TFS   = 4'd6;
  localparam logic [2:0] OP2_TFS   = 3'd0;

  function automatic logic [ACT_W-1:0] one_act(input int idx);
    return ACT_W'(1) << idx;
  endfunction

  // Outcome of a denied EL3 tag-access check.
  function automatic logic [ACT_W-1:0] el3_deny(input logic sdd);
    return sdd ? one_act(A_UNDEF) : one_act(A_TRAP3);
  endfunction
endpackage

// File: rtl/tfs_enc_match.sv
module tfs_enc_match
  import tfs_pkg::*;
(
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output form_e      form
);
  logic common_ok;
  assign common_ok = (op0 == OP0_SYS) && (crn == CRN_TFS) &&
                     (crm == CRM_TFS) && (op2 == OP2_TFS);

  always_comb begin
    form = F_NONE;
    if (common_ok) begin
      if (op1 == OP1_PRI)        form = F_PRI;
      else if (op1 == OP1_ALIAS) form = F_ALIAS;
      else if (op1 == OP1_EL2R)  form = F_EL2R;
    end
  end
endmodule

// File: rtl/tfs_gate.sv
module tfs_gate (
  input  logic el2_present,
  input  logic el3_present,
  input  logic el2_enabled,
  input  logic el2_tag_en,
  input  logic el3_tag_en,
  input  logic sdd_prio,
  output logic prio_undef,
  output logic el2_block,
  output logic el3_block
);
  assign el3_block  = el3_present & ~el3_tag_en;
  assign prio_undef = el3_block & sdd_prio;
  assign el2_block  = el2_present & el2_enabled & ~el2_tag_en;
endmodule

// File: rtl/tfs_resolve.sv
module tfs_resolve
  import tfs_pkg::*;
#(
  parameter int              EC_W    = 6,
  parameter logic [EC_W-1:0] EC_VAL  = 6'h18,
  parameter int              OFS_W   = 12,
  parameter logic [OFS_W-1:0] OFS_VAL = 12'h190
) (
  input  form_e             form,
  input  logic [1:0]        cur_el,
  input  logic [2:0]        nv,
  input  logic              host_mode,
  input  logic              prio_undef,
  input  logic              el2_block,
  input  logic              el3_block,
  input  logic              sdd_undef,
  output logic [ACT_W-1:0]  act,
  output logic [EC_W-1:0]   exc_class,
  output logic [OFS_W-1:0]  mem_offset
);
  // Shared check chain: (a), optional (c), (d), then the final result.
  function automatic logic [ACT_W-1:0] gated(input logic use_el2,
                                             input logic [ACT_W-1:0] pass);
    if (prio_undef)            return one_act(A_UNDEF);
    if (use_el2 && el2_block)  return one_act(A_TRAP2);
    if (el3_block)             return el3_deny(sdd_undef);
    return pass;
  endfunction

  always_comb begin
    act = '0;
    case (form)
      F_PRI: begin
        case (cur_el)
          2'd0: act = one_act(A_UNDEF);
          2'd1: begin
            if (prio_undef)         act = one_act(A_UNDEF);
            else if (nv == 3'b011)  act = one_act(A_TRAP2);
            else if (el2_block)     act = one_act(A_TRAP2);
            else if (el3_block)     act = el3_deny(sdd_undef);
            else if (nv == 3'b111)  act = one_act(A_MEM);
            else                    act = one_act(A_EL1);
          end
          2'd2: act = gated(1'b0, host_mode ? one_act(A_EL2) : one_act(A_EL1));
          default: act = one_act(A_EL1);
        endcase
      end
      F_ALIAS: begin
        case (cur_el)
          2'd0: act = one_act(A_UNDEF);
          2'd1: begin
            if (nv == 3'b101)  act = one_act(A_MEM);
            else if (nv[0])    act = one_act(A_TRAP2);
            else               act = one_act(A_UNDEF);
          end
          2'd2: act = host_mode ? gated(1'b0, one_act(A_EL1)) : one_act(A_UNDEF);
          default: act = host_mode ? one_act(A_EL1) : one_act(A_UNDEF);
        endcase
      end
      F_EL2R: begin
        case (cur_el)
          2'd0: act = one_act(A_UNDEF);
          2'd1: begin
            if (nv[2] && nv[0])  act = gated(1'b1, one_act(A_EL1));
            else if (nv[0])      act = one_act(A_TRAP2);
            else                 act = one_act(A_UNDEF);
          end
          2'd2: act = gated(1'b0, one_act(A_EL2));
          default: act = one_act(A_EL2);
        endcase
      end
      default: act = '0;
    endcase
  end

  assign exc_class  = (act[A_TRAP2] | act[A_TRAP3]) ? EC_VAL : '0;
  assign mem_offset = act[A_MEM] ? OFS_VAL : '0;
endmodule

// File: rtl/tfs_access_decoder.sv
module tfs_access_decoder
  import tfs_pkg::*;
#(
  parameter int               EC_W    = 6,
  parameter logic [EC_W-1:0]  EC_VAL  = 6'h18,
  parameter int               OFS_W   = 12,
  parameter logic [OFS_W-1:0] OFS_VAL = 12'h190
) (
  input  logic [1:0]       cur_el,
  input  logic [1:0]       enc_op0,
  input  logic [2:0]       enc_op1,
  input  logic [3:0]       enc_crn,
  input  logic [3:0]       enc_crm,
  input  logic [2:0]       enc_op2,
  input  logic             is_write,
  input  logic             el2_present,
  input  logic             el3_present,
  input  logic             el2_enabled,
  input  logic             host_mode,
  input  logic [2:0]       nv,
  input  logic             el2_tag_en,
  input  logic             el3_tag_en,
  input  logic             sdd_prio,
  input  logic             sdd_undef,
  output logic [5:0]       act,
  output logic             no_match,
  output logic [EC_W-1:0]  exc_class,
  output logic [OFS_W-1:0] mem_offset,
  output logic             wr_en
);
  form_e form;
  logic  prio_undef, el2_block, el3_block;
  logic  stores_data;

  tfs_enc_match u_match (
    .op0(enc_op0), .op1(enc_op1), .crn(enc_crn), .crm(enc_crm), .op2(enc_op2),
    .form(form)
  );

  tfs_gate u_gate (
    .el2_present(el2_present), .el3_present(el3_present),
    .el2_enabled(el2_enabled), .el2_tag_en(el2_tag_en),
    .el3_tag_en(el3_tag_en), .sdd_prio(sdd_prio),
    .prio_undef(prio_undef), .el2_block(el2_block), .el3_block(el3_block)
  );

  tfs_resolve #(.EC_W(EC_W), .EC_VAL(EC_VAL), .OFS_W(OFS_W), .OFS_VAL(OFS_VAL)) u_res (
    .form(form), .cur_el(cur_el), .nv(nv), .host_mode(host_mode),
    .prio_undef(prio_undef), .el2_block(el2_block), .el3_block(el3_block),
    .sdd_undef(sdd_undef), .act(act), .exc_class(exc_class),
    .mem_offset(mem_offset)
  );

  assign no_match    = (form == F_NONE);
  assign stores_data = act[A_EL1] | act[A_EL2] | act[A_MEM];
  assign wr_en       = is_write & stores_data;

  always_comb begin
    p_quiet_nomatch_r1: assert (!no_match || (act == '0 && exc_class == '0))
      else $error("no_match with action asserted");
    p_onehot_act_r9: assert (no_match || $countones(act) == 1)
      else $error("action not one-hot");
    p_el0_undef_r2: assert (no_match || cur_el != 2'd0 || act[A_UNDEF])
      else $error("EL0 access not undefined");
    p_trap_class_r10: assert (((act[A_TRAP2] | act[A_TRAP3]) != 1'b0) == (exc_class == EC_VAL))
      else $error("syndrome class mismatch");
    p_mem_offset_r10: assert (act[A_MEM] == (mem_offset == OFS_VAL))
      else $error("redirect offset mismatch");
    p_el3_primary_r4: assert (!(form == F_PRI && cur_el == 2'd3) || act[A_EL1])
      else $error("EL3 primary not EL1 copy");
  end
endmodule

// File: tb/test_tfs_access_decoder.sv
module test_tfs_access_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0] cur_el;
  logic [1:0] op0;
  logic [2:0] op1, op2;
  logic [3:0] crn, crm;
  logic is_write, el2_present, el3_present, el2_enabled, host_mode;
  logic [2:0] nv;
  logic el2_tag_en, el3_tag_en, sdd_prio, sdd_undef;
  logic [5:0] act;
  logic no_match, wr_en;
  logic [5:0] exc_class;
  logic [11:0] mem_offset;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  tfs_access_decoder i_tfs_access_decoder (
    .cur_el(cur_el), .enc_op0(op0), .enc_op1(op1), .enc_crn(crn), .enc_crm(crm),
    .enc_op2(op2), .is_write(is_write), .el2_present(el2_present),
    .el3_present(el3_present), .el2_enabled(el2_enabled), .host_mode(host_mode),
    .nv(nv), .el2_tag_en(el2_tag_en), .el3_tag_en(el3_tag_en),
    .sdd_prio(sdd_prio), .sdd_undef(sdd_undef), .act(act), .no_match(no_match),
    .exc_class(exc_class), .mem_offset(mem_offset), .wr_en(wr_en)
  );

  // Reference: returns action index (0..5) or -1 for no match; tag names the rule used.
  function automatic int model(input int el, input int kind, output string tag);
    bit a_fail, c_fail, d_fail;
    int d_res;
    a_fail = el3_present && !el3_tag_en && sdd_prio;
    c_fail = el2_present && el2_enabled && !el2_tag_en;
    d_fail = el3_present && !el3_tag_en;
    d_res  = sdd_undef ? 0 : 2;
    tag = "R1";
    if (kind > 2) return -1;
    if (el == 0) begin tag = "R2"; return 0; end
    if (kind == 0) begin
      if (el == 1) begin
        tag = "R3";
        if (a_fail) return 0;
        if (nv == 3'b011 || c_fail) return 1;
        if (d_fail) return d_res;
        return (nv == 3'b111) ? 5 : 3;
      end
      tag = "R4";
      if (el == 3) return 3;
      if (a_fail) return 0;
      if (d_fail) return d_res;
      return host_mode ? 4 : 3;
    end
    if (kind == 1) begin
      if (el == 1) begin
        tag = "R5";
        if (nv == 3'b101) return 5;
        return nv[0] ? 1 : 0;
      end
      tag = "R6";
      if (!host_mode) return 0;
      if (el == 2 && a_fail) return 0;
      if (el == 2 && d_fail) return d_res;
      return 3;
    end
    if (el == 1) begin
      tag = "R7";
      if (!nv[0]) return 0;
      if (!nv[2]) return 1;
      if (a_fail) return 0;
      if (c_fail) return 1;
      if (d_fail) return d_res;
      return 3;
    end
    tag = "R8";
    if (el == 3) return 4;
    if (a_fail) return 0;
    if (d_fail) return d_res;
    return 4;
  endfunction

  task automatic set_enc(input int kind);
    op0 = 2'd3; op1 = 3'd0; crn = 4'd5; crm = 4'd6; op2 = 3'd0;
    case (kind)
      1: op1 = 3'd5;
      2: op1 = 3'd4;
      3: op1 = 3'd1;
      4: crm = 4'd7;
      5: op0 = 2'd2;
      default: ;
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  initial begin
    {cur_el, op0, op1, crn, crm, op2, is_write, el2_present, el3_present,
     el2_enabled, host_mode, nv, el2_tag_en, el3_tag_en, sdd_prio, sdd_undef} = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(no_match == 1'b1 && act == 6'd0 && wr_en == 1'b0, "R1", "idle no_match/act",
        {no_match, act}, 7'h40);
    for (int el = 0; el < 4; el++) begin
      for (int kind = 0; kind < 6; kind++) begin
        for (int w = 0; w < 2; w++) begin
          for (int c = 0; c < 2048; c++) begin
            @(posedge clk);
            cur_el = 2'(el);
            set_enc(kind);
            is_write = w[0];
            {el2_present, el3_present, el2_enabled, host_mode, nv,
             el2_tag_en, el3_tag_en, sdd_prio, sdd_undef} = 11'(c);
            @(negedge clk);
            begin
              string tag;
              int code;
              logic [5:0] e_act;
              bit trap, store;
              code  = model(el, kind, tag);
              e_act = (code < 0) ? 6'd0 : 6'(1 << code);
              trap  = (code == 1 || code == 2);
              store = (code >= 3);
              chk(act == e_act, tag, "act (R9 encoding)", act, e_act);
              chk(no_match == (code < 0), "R1", "no_match", no_match, code < 0);
              chk(exc_class == (trap ? 6'h18 : 6'h0), "R10", "exc_class",
                  exc_class, trap ? 6'h18 : 6'h0);
              chk(mem_offset == (code == 5 ? 12'h190 : 12'h0), "R10", "mem_offset",
                  mem_offset, code == 5 ? 12'h190 : 12'h0);
              chk(wr_en == (w[0] && store), "R11", "wr_en", wr_en, w[0] && store);
            end
          end
        end
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule